// File: doc/BRIEF.md
# Counter Bank Serial Transmitter

This block reads out a bank of latched counter values over one serial line. A multiplexer picks one byte at a time from the snapshot bank. A synchronous state machine wraps each byte in an asynchronous character with start, data, parity and stop bits. The machine runs on the transmit clock supplied from outside, so one line bit goes out per clock period and the clock rate sets the baud rate.

A readout runs while `tx_en` stays high. It walks every channel in order and then raises `done_o`. The host can drop and raise `tx_en` to send the whole readout again.

For daisy-chaining, `done_o` of one device drives `tx_en` of the next device. The serial outputs of all devices are ANDed onto one shared line. This works because an inactive device holds its line high. A short mode sends only the low 15 bits of each channel, which halves the number of characters.

Top module: `cnt_frame_tx`

## Requirements
- R1: Each character takes 11 clock periods on `ser_o`, in this order:
  - a start bit of 0;
  - the eight data bits, least significant first;
  - an even-parity bit, equal to the XOR of the eight data bits;
  - a stop bit of 1.
  
  Characters follow each other with no gap.
- R2: In normal mode (`short_mode`=0), channels go out in order 0 to 15. Channel n is `counts_i[32n+31:32n]`. Each channel sends 4 bytes, least significant byte first, for 64 characters in total.
- R3: In short mode (`short_mode`=1), each channel sends only bits 7:0 and then bits 15:8, with bit 15 sent as 0, for 32 characters in total. Bits 31:16 are never sent. `short_mode` must stay stable during a readout.
- R4: Suppose the block is idle and the clock edge at which it first samples `tx_en` high is edge E. The start bit of character 0 is on `ser_o` after edge E. Bit k of the readout is on `ser_o` after edge E+k.
- R5: If a clock edge samples `tx_en` low during a readout, `ser_o` is 1 and `done_o` is 0 after that edge. Raising `tx_en` again restarts the readout at channel 0, byte 0.
- R6: For N characters, `done_o` rises after edge E+11N. It stays high while `tx_en` stays high, and clears after the first edge that samples `tx_en` low.
- R7: `ser_o` is 1 whenever no character is being sent: after reset, while idle, and while `done_o` is high.
- R8: Connect `done_o` of one device to `tx_en` of a second device, and AND their `ser_o` outputs. The shared line then carries the first readout, then one idle bit, then the second readout.
- R9: While reset is asserted, `ser_o` is 1 and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one line bit per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; a low level aborts the readout |
| short_mode | input | 1 | 1 selects the 15-bit-per-channel format |
| counts_i | input | 512 | Latched counter snapshot, 16 channels × 32 bits |
| ser_o | output | 1 | Serial data line, high when idle |
| done_o | output | 1 | End of readout; enable for the next device |

## Verification
A stale channel or byte pointer shows up at once as wrong data bits in the next character on `ser_o`. A skipped or repeated byte moves the rise of `done_o` away from the edge expected for the 11N-bit readout. A miscounted bit position breaks the start/stop framing within 11 clocks. A missed abort or restart shows as line activity after `tx_en` falls, or as a first character that is not channel 0, byte 0. Every bit of each readout is compared against its expected position, so any of these faults is caught within one character time.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_DONE = 2'd2
    } tx_state_e;

    localparam int unsigned POS_W     = 4;
    localparam int unsigned DATA_BITS = 8;
    localparam logic [POS_W-1:0] POS_START = 4'd0;
    localparam logic [POS_W-1:0] POS_LAST_DATA = 4'd8;
    localparam logic [POS_W-1:0] POS_PARITY = 4'd9;
    localparam logic [POS_W-1:0] POS_STOP = 4'd10;

endpackage

// File: rtl/ctx_byte_mux.sv
module ctx_byte_mux #(
    parameter int unsigned NUM_CH     = 16,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned SHORT_BITS = 15,
    parameter int unsigned CH_W       = 4,
    parameter int unsigned BY_W       = 2
) (
    input  logic [NUM_CH*CNT_W-1:0] counts_i,
    input  logic [CH_W-1:0]         ch_i,
    input  logic [BY_W-1:0]         by_i,
    input  logic                    short_mode,
    output logic [7:0]              byte_o
);

    logic [CNT_W-1:0] word;
    logic [7:0]       raw;
    logic [7:0]       keep;

    assign word = counts_i[int'(ch_i)*CNT_W +: CNT_W];
    assign raw  = word[int'(by_i)*8 +: 8];

    // Short mode clears bits whose position in the channel word lies above the short width
    for (genvar gi = 0; gi < 8; gi++) begin : g_keep
        assign keep[gi] = !short_mode || ((int'(by_i) * 8 + gi) < int'(SHORT_BITS));
    end

    assign byte_o = raw & keep;

endmodule

// File: rtl/ctx_tx_fsm.sv
module ctx_tx_fsm
    import ctx_pkg::*;
#(
    parameter int unsigned NUM_CH      = 16,
    parameter int unsigned BYTES_LONG  = 4,
    parameter int unsigned BYTES_SHORT = 2,
    parameter int unsigned CH_W        = 4,
    parameter int unsigned BY_W        = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_en,
    input  logic            short_mode,
    input  logic [7:0]      byte_i,
    output logic [CH_W-1:0] ch_o,
    output logic [BY_W-1:0] by_o,
    output logic            ser_o,
    output logic            done_o
);

    localparam logic [CH_W-1:0] LAST_CH  = CH_W'(NUM_CH - 1);
    localparam logic [BY_W-1:0] LAST_BYL = BY_W'(BYTES_LONG - 1);
    localparam logic [BY_W-1:0] LAST_BYS = BY_W'(BYTES_SHORT - 1);

    typedef struct packed {
        tx_state_e        st;
        logic [CH_W-1:0]  ch;
        logic [BY_W-1:0]  by;
        logic [POS_W-1:0] pos;
        logic [7:0]       sh;
        logic             par;
        logic             last;
        logic             ser;
        logic             done;
    } regs_t;

    regs_t r_q, r_d;
    logic [BY_W-1:0] last_by;

    assign last_by = short_mode ? LAST_BYS : LAST_BYL;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.ch   = '0;
                r_d.by   = '0;
                r_d.last = 1'b0;
                r_d.ser  = 1'b1;
                r_d.done = 1'b0;
                if (tx_en) begin
                    r_d.st  = ST_SEND;
                    r_d.pos = POS_START;
                    r_d.ser = 1'b0;
                    r_d.sh  = byte_i;
                    r_d.par = ^byte_i;
                end
            end
            ST_SEND: begin
                if (!tx_en) begin
                    r_d.st   = ST_IDLE;
                    r_d.ser  = 1'b1;
                    r_d.ch   = '0;
                    r_d.by   = '0;
                    r_d.last = 1'b0;
                end else if (r_q.pos != POS_STOP) begin
                    r_d.pos = r_q.pos + 1'b1;
                    if (r_q.pos < POS_LAST_DATA) begin
                        r_d.ser = r_q.sh[0];
                        r_d.sh  = r_q.sh >> 1;
                    end else if (r_q.pos == POS_LAST_DATA) begin
                        r_d.ser = r_q.par;
                        // pointer moves once the shifter no longer needs the byte
                        if (r_q.by == last_by) begin
                            if (r_q.ch == LAST_CH) begin
                                r_d.last = 1'b1;
                            end else begin
                                r_d.by = '0;
                                r_d.ch = r_q.ch + 1'b1;
                            end
                        end else begin
                            r_d.by = r_q.by + 1'b1;
                        end
                    end else begin
                        r_d.ser = 1'b1;
                    end
                end else if (r_q.last) begin
                    r_d.st   = ST_DONE;
                    r_d.ser  = 1'b1;
                    r_d.done = 1'b1;
                end else begin
                    r_d.pos = POS_START;
                    r_d.ser = 1'b0;
                    r_d.sh  = byte_i;
                    r_d.par = ^byte_i;
                end
            end
            ST_DONE: begin
                r_d.ser  = 1'b1;
                r_d.done = 1'b1;
                if (!tx_en) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b0;
                    r_d.ch   = '0;
                    r_d.by   = '0;
                    r_d.last = 1'b0;
                end
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.ser = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.ser  <= 1'b1;
            r_q.done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ch_o   = r_q.ch;
    assign by_o   = r_q.by;
    assign ser_o  = r_q.ser;
    assign done_o = r_q.done;

    // R1
    char_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SEND && r_q.pos == POS_STOP && tx_en) |=> (done_o || !ser_o));

    // R3
    short_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SEND && short_mode) |-> (r_q.by <= LAST_BYS));

    // R4
    start_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && tx_en) |=> (!ser_o && r_q.ch == '0 && r_q.by == '0));

    // R5
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SEND && !tx_en) |=> (ser_o && !done_o));

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && tx_en) |=> done_o);

    // R6
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en) |=> !done_o);

    // R7
    quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_SEND) |-> ser_o);

endmodule

// File: rtl/cnt_frame_tx.sv
module cnt_frame_tx #(
    parameter int unsigned NUM_CH     = 16,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned SHORT_BITS = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tx_en,
    input  logic                    short_mode,
    input  logic [NUM_CH*CNT_W-1:0] counts_i,
    output logic                    ser_o,
    output logic                    done_o
);

    localparam int unsigned BYTES_LONG  = CNT_W / 8;
    localparam int unsigned BYTES_SHORT = (SHORT_BITS + 7) / 8;
    localparam int unsigned CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int unsigned BY_W        = (BYTES_LONG > 1) ? $clog2(BYTES_LONG) : 1;

    logic [CH_W-1:0] ch_sel;
    logic [BY_W-1:0] by_sel;
    logic [7:0]      cur_byte;

    ctx_byte_mux #(
        .NUM_CH    (NUM_CH),
        .CNT_W     (CNT_W),
        .SHORT_BITS(SHORT_BITS),
        .CH_W      (CH_W),
        .BY_W      (BY_W)
    ) i_mux (
        .counts_i  (counts_i),
        .ch_i      (ch_sel),
        .by_i      (by_sel),
        .short_mode(short_mode),
        .byte_o    (cur_byte)
    );

    ctx_tx_fsm #(
        .NUM_CH     (NUM_CH),
        .BYTES_LONG (BYTES_LONG),
        .BYTES_SHORT(BYTES_SHORT),
        .CH_W       (CH_W),
        .BY_W       (BY_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .short_mode(short_mode),
        .byte_i    (cur_byte),
        .ch_o      (ch_sel),
        .by_o      (by_sel),
        .ser_o     (ser_o),
        .done_o    (done_o)
    );

endmodule

// File: tb/test_cnt_frame_tx.sv
module test_cnt_frame_tx;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int W   = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0;
    logic short_mode = 1'b0;
    logic [NCH*W-1:0] bank_a = '0;
    logic [NCH*W-1:0] bank_b = '0;
    logic ser_a, done_a, ser_b, done_b;
    logic line;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cnt_frame_tx i_cnt_frame_tx (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .short_mode(short_mode),
        .counts_i(bank_a), .ser_o(ser_a), .done_o(done_a)
    );

    cnt_frame_tx i_cnt_frame_tx_next (
        .clk(clk), .rst_n(rst_n), .tx_en(done_a), .short_mode(short_mode),
        .counts_i(bank_b), .ser_o(ser_b), .done_o(done_b)
    );

    assign line = ser_a & ser_b;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NCH*W-1:0] make_bank(input int kind);
        logic [NCH*W-1:0] b;
        for (int c = 0; c < NCH; c++) begin
            logic [W-1:0] v;
            case (kind)
                0: v = (32'h9E3779B9 * (c + 1)) ^ {c[7:0], 24'h5A0F33};
                1: v = '1;
                2: v = '0;
                default: v = 32'h01234567 + c * 32'h11111111;
            endcase
            b[c*W +: W] = v;
        end
        return b;
    endfunction

    function automatic int nchars(input logic sh);
        return NCH * (sh ? 2 : 4);
    endfunction

    // Expected line bit k of a readout (R1 framing, R2 order, R3 short masking)
    function automatic logic exp_bit(input logic [NCH*W-1:0] bk, input logic sh, input int k);
        int bpc, c, p, ch, b;
        logic [W-1:0] w;
        logic [7:0] by;
        bpc = sh ? 2 : 4;
        c  = k / 11;
        p  = k % 11;
        ch = c / bpc;
        b  = c % bpc;
        w  = bk[ch*W +: W];
        by = w[b*8 +: 8];
        if (sh && b == 1) by[7] = 1'b0;
        if (p == 0) return 1'b0;
        if (p <= 8) return by[p-1];
        if (p == 9) return ^by;
        return 1'b1;
    endfunction

    // Full readout on the first device, every bit checked (R1 R2 R3 R4 R6 R7)
    task automatic run_stream(input logic sh, input string tag);
        int nb;
        nb = 11 * nchars(sh);
        short_mode = sh;
        @(negedge clk);
        tx_en = 1'b1;
        for (int k = 0; k < nb; k++) begin
            logic e;
            @(negedge clk);
            e = exp_bit(bank_a, sh, k);
            chk(ser_a === e, tag, int'(ser_a), int'(e));
            if (done_a !== 1'b0) chk(1'b0, "R6 early done", int'(done_a), 0);
        end
        @(negedge clk);
        chk(done_a === 1'b1, "R6 done rise", int'(done_a), 1);
        chk(ser_a === 1'b1, "R7 line high at done", int'(ser_a), 1);
        for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            chk(done_a === 1'b1, "R6 done held", int'(done_a), 1);
        end
        tx_en = 1'b0;
        @(negedge clk);
        chk(done_a === 1'b0, "R6 done clear", int'(done_a), 0);
        chk(ser_a === 1'b1, "R7 idle line", int'(ser_a), 1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bank_a = make_bank(0);
        bank_b = make_bank(3);
        repeat (3) @(negedge clk);
        // R9
        chk(ser_a === 1'b1, "R9 reset ser", int'(ser_a), 1);
        chk(done_a === 1'b0, "R9 reset done", int'(done_a), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ser_a === 1'b1, "R7 idle after reset", int'(ser_a), 1);

        run_stream(1'b0, "R2 normal pattern");
        run_stream(1'b1, "R3 short pattern");
        bank_a = make_bank(1);
        run_stream(1'b0, "R1 all ones");
        run_stream(1'b1, "R3 all ones short");
        bank_a = make_bank(2);
        run_stream(1'b0, "R1 all zeros");
        bank_a = make_bank(3);

        // R5 abort in the middle of a character, then restart from channel 0
        short_mode = 1'b0;
        @(negedge clk);
        tx_en = 1'b1;
        for (int k = 0; k < 47; k++) begin
            logic e;
            @(negedge clk);
            e = exp_bit(bank_a, 1'b0, k);
            chk(ser_a === e, "R4 pre-abort bits", int'(ser_a), int'(e));
        end
        tx_en = 1'b0;
        for (int h = 0; h < 4; h++) begin
            @(negedge clk);
            chk(ser_a === 1'b1, "R5 abort line high", int'(ser_a), 1);
            chk(done_a === 1'b0, "R5 abort no done", int'(done_a), 0);
        end
        run_stream(1'b0, "R5 restart from channel 0");

        // R8 two devices chained on one line
        bank_a = make_bank(0);
        short_mode = 1'b0;
        @(negedge clk);
        tx_en = 1'b1;
        for (int k = 0; k < 11 * 64; k++) begin
            logic e;
            @(negedge clk);
            e = exp_bit(bank_a, 1'b0, k);
            chk(line === e, "R8 chain first", int'(line), int'(e));
        end
        @(negedge clk);
        chk(line === 1'b1, "R8 gap bit", int'(line), 1);
        for (int k = 0; k < 11 * 64; k++) begin
            logic e;
            @(negedge clk);
            e = exp_bit(bank_b, 1'b0, k);
            chk(line === e, "R8 chain second", int'(line), int'(e));
        end
        @(negedge clk);
        chk(done_b === 1'b1, "R8 second done", int'(done_b), 1);
        chk(line === 1'b1, "R8 line idle", int'(line), 1);
        tx_en = 1'b0;
        @(negedge clk);
        chk(done_a === 1'b0, "R8 first done clear", int'(done_a), 0);
        @(negedge clk);
        chk(done_b === 1'b0, "R8 second done clear", int'(done_b), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule